// File: doc/BRIEF.md
# Single-Wire Carrier Sense Detector

This block watches one shared, already synchronised data line and tells the local transmitter and the frame-splitting logic above it whether the medium is in use. Any high sample marks the line busy. A continuous low stretch of one byte time releases busy. A further, software-chosen margin declares the line idle. A single-cycle strobe marks each entry into idle, so downstream logic can close the frame it has been collecting.

The byte time follows from a two-bit timing mode. Each mode fixes a data-bit duration and a pad-bit duration in microseconds. One byte time is one pad bit plus nine data bits. The extra idle margin is an input in whole microseconds. The parameter `TICKS_PER_US` converts every duration into clock cycles.

Top module: `carrier_sense`

## Requirements
- R1: A high sample on `line_i` sets `busy_o` to 1 and `idle_o` to 0 on that same clock edge. The low-run measurement restarts from zero.
- R2: The byte time is (pad + 9 × data) µs × `TICKS_PER_US` cycles. The (data, pad) pairs in µs are: `mode_i`=0 → (44,116), 1 → (40,92), 2 → (28,88), 3 → (26,60). This gives 512, 452, 340 and 294 µs.
- R3: `busy_o` falls on the edge that takes the byte-time-th consecutive low sample. Until that edge, a busy line stays busy.
- R4: `idle_o` rises on the edge that takes the (byte time + `extra_idle_us_i` × `TICKS_PER_US`)-th consecutive low sample. With a margin of 0, idle rises on the same edge on which busy falls.
- R5: While `rst_n` is low, all three outputs are 0. The first low sample after reset starts a measurement, even though no high was seen before it.
- R6: `idle_enter_o` is high for exactly one cycle each time idle is entered, in the cycle in which `idle_o` first reads 1.
- R7: `busy_o` and `idle_o` are never both 1. Between the fall of busy and the rise of idle, both read 0.
- R8: The low-run counter saturates at the idle threshold. An arbitrarily long low period keeps `idle_o` at 1 and raises no further strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Synchronised level of the shared line |
| mode_i | input | 2 | Timing mode select (0..3) |
| extra_idle_us_i | input | EXTRA_W | Idle margin beyond one byte time, in µs |
| busy_o | output | 1 | Medium in use |
| idle_o | output | 1 | Medium idle |
| idle_enter_o | output | 1 | One-cycle strobe on idle entry |

## Verification
The embedded properties check, on every cycle, several invariants:
- a high sample forces busy and clears idle;
- busy never falls and idle never holds without a preceding low sample;
- the strobe coincides with the rise of idle;
- busy and idle are never both set;
- the run counter never wraps during a long low period.

The exact cycle on which busy falls and idle rises can only be shown by the bench scenarios. Those scenarios cover each timing mode and several margins, the measurement that starts right after reset, a short high glitch that restarts the count, and a low period far longer than the threshold.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef struct packed {
    logic [9:0] data_us;
    logic [9:0] pad_us;
  } bit_times_t;

  localparam int unsigned DATA_SLOTS_PER_BYTE = 9;
  localparam int unsigned LONGEST_BYTE_US     = 512;

  function automatic bit_times_t mode_times(input logic [1:0] sel);
    bit_times_t t;
    case (sel)
      2'd0:    begin t.data_us = 10'd44; t.pad_us = 10'd116; end
      2'd1:    begin t.data_us = 10'd40; t.pad_us = 10'd92;  end
      2'd2:    begin t.data_us = 10'd28; t.pad_us = 10'd88;  end
      default: begin t.data_us = 10'd26; t.pad_us = 10'd60;  end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/cs_threshold.sv
module cs_threshold #(
  parameter int TICKS_PER_US = 2,
  parameter int EXTRA_W      = 8,
  parameter int CNT_W        = 12
) (
  input  logic [1:0]         mode_i,
  input  logic [EXTRA_W-1:0] extra_us_i,
  output logic [CNT_W-1:0]   byte_cyc_o,
  output logic [CNT_W-1:0]   idle_cyc_o
);
  import cs_pkg::*;

  bit_times_t        times;
  logic [CNT_W-1:0]  byte_us;
  logic [CNT_W-1:0]  idle_us;

  always_comb begin
    times   = mode_times(mode_i);
    byte_us = CNT_W'(times.pad_us) + CNT_W'(DATA_SLOTS_PER_BYTE) * CNT_W'(times.data_us);
    idle_us = byte_us + CNT_W'(extra_us_i);
  end

  generate
    if (TICKS_PER_US == 1) begin : g_unit
      assign byte_cyc_o = byte_us;
      assign idle_cyc_o = idle_us;
    end else begin : g_scaled
      assign byte_cyc_o = byte_us * CNT_W'(TICKS_PER_US);
      assign idle_cyc_o = idle_us * CNT_W'(TICKS_PER_US);
    end
  endgenerate

endmodule

// File: rtl/cs_low_timer.sv
module cs_low_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] run_next_o
);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_d;
  logic             run_en;

  always_comb begin
    run_en = line_i || (run_q < limit_i);
    run_d  = line_i ? '0 : run_q + CNT_W'(1);
    run_next_o = run_en ? run_d : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  // R8: a running low count never wraps back to zero
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_i && run_q != '0) |=> (run_q != '0));

endmodule

// File: rtl/cs_flags.sv
module cs_flags #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic [CNT_W-1:0] run_next_i,
  input  logic [CNT_W-1:0] byte_cyc_i,
  input  logic [CNT_W-1:0] idle_cyc_i,
  output logic             busy_o,
  output logic             idle_o,
  output logic             enter_o
);

  logic busy_q, idle_q, enter_q;
  logic busy_d, idle_d, enter_d;

  always_comb begin
    busy_d  = line_i | (busy_q & (run_next_i < byte_cyc_i));
    idle_d  = ~line_i & (run_next_i >= idle_cyc_i);
    enter_d = idle_d & ~idle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idle_q  <= 1'b0;
      enter_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      idle_q  <= idle_d;
      enter_q <= enter_d;
    end
  end

  assign busy_o  = busy_q;
  assign idle_o  = idle_q;
  assign enter_o = enter_q;

  // R1: a high sample yields busy and not idle
  a_r1_high_busy: assert property (@(posedge clk) disable iff (!rst_n)
    line_i |=> (busy_q && !idle_q));

  // R3: busy only drops after a low sample
  a_r3_fall_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !$past(line_i));

  // R4: idle is only held after a low sample
  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |-> !$past(line_i));

  // R6: the strobe coincides with the rise of idle
  a_r6_strobe_rise: assert property (@(posedge clk) disable iff (!rst_n)
    enter_q |-> (idle_q && !$past(idle_q)));

  a_r6_rise_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> enter_q);

  // R7: busy and idle are exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && idle_q));

endmodule

// File: rtl/carrier_sense.sv
module carrier_sense #(
  parameter int TICKS_PER_US = 2,
  parameter int EXTRA_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_i,
  input  logic [1:0]         mode_i,
  input  logic [EXTRA_W-1:0] extra_idle_us_i,
  output logic               busy_o,
  output logic               idle_o,
  output logic               idle_enter_o
);

  localparam int MAX_CYC = (int'(cs_pkg::LONGEST_BYTE_US) + (2 ** EXTRA_W) - 1) * TICKS_PER_US;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] byte_cyc;
  logic [CNT_W-1:0] idle_cyc;
  logic [CNT_W-1:0] run_next;

  cs_threshold #(
    .TICKS_PER_US(TICKS_PER_US),
    .EXTRA_W     (EXTRA_W),
    .CNT_W       (CNT_W)
  ) u_thr (
    .mode_i    (mode_i),
    .extra_us_i(extra_idle_us_i),
    .byte_cyc_o(byte_cyc),
    .idle_cyc_o(idle_cyc)
  );

  cs_low_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (line_i),
    .limit_i   (idle_cyc),
    .run_next_o(run_next)
  );

  cs_flags #(.CNT_W(CNT_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (line_i),
    .run_next_i(run_next),
    .byte_cyc_i(byte_cyc),
    .idle_cyc_i(idle_cyc),
    .busy_o    (busy_o),
    .idle_o    (idle_o),
    .enter_o   (idle_enter_o)
  );

endmodule

// File: tb/tb_carrier_sense.sv
`timescale 1ns/1ps
module tb_carrier_sense;

  localparam int TICKS = 2;
  localparam int EW    = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          line;
  logic [1:0]    mode;
  logic [EW-1:0] extra;
  logic          busy, idle, enter;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  carrier_sense #(.TICKS_PER_US(TICKS), .EXTRA_W(EW)) dut (
    .clk(clk), .rst_n(rst_n), .line_i(line), .mode_i(mode),
    .extra_idle_us_i(extra), .busy_o(busy), .idle_o(idle),
    .idle_enter_o(enter)
  );

  function automatic int byte_cycles(input int m);
    int us;
    case (m)
      0: us = 116 + 9 * 44;
      1: us = 92 + 9 * 40;
      2: us = 88 + 9 * 28;
      default: us = 60 + 9 * 26;
    endcase
    return us * TICKS;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_run;
  bit m_busy, m_idle, m_enter;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_busy = 0; m_idle = 0; m_enter = 0;
    end else begin
      int bt, it;
      bit nid;
      bt = byte_cycles(int'(mode));
      it = bt + int'(extra) * TICKS;
      if (line) begin
        m_run = 0; m_busy = 1; nid = 0;
      end else begin
        if (m_run < it) m_run = m_run + 1;
        if (m_run >= bt) m_busy = 0;
        nid = (m_run >= it);
      end
      m_enter = nid && !m_idle;
      m_idle = nid;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R1/R3 busy per-cycle", busy, m_busy);
      chk(idle == m_idle, "R4 idle per-cycle", idle, m_idle);
      chk(enter == m_enter, "R6 strobe per-cycle", enter, m_enter);
      chk(!(busy && idle), "R7 exclusive", busy & idle, 0);
    end
  end

  // low run: returns negedge index of busy fall and idle rise
  task automatic low_run(input int limit, output int fall_n, output int rise_n, output int strobes);
    fall_n = 0; rise_n = 0; strobes = 0;
    line = 1'b0;
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      if (!busy && fall_n == 0) fall_n = n;
      if (idle && rise_n == 0) rise_n = n;
      if (enter) strobes++;
    end
  endtask

  task automatic pulse_high(input int k);
    line = 1'b1;
    repeat (k) @(negedge clk);
    chk(busy == 1'b1 && idle == 1'b0, "R1 high gives busy", {busy, idle}, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f, r, s, bt;
    rst_n = 1'b0; line = 1'b0; mode = 2'd0; extra = 8'd4;
    repeat (3) @(negedge clk);
    chk(busy == 0 && idle == 0 && enter == 0, "R5 reset state", {busy, idle, enter}, 0);
    rst_n = 1'b1;

    // R5: measurement starts at first low after reset
    low_run(1100, f, r, s);
    chk(r == (512 + 4) * TICKS, "R5 idle after reset", r, (512 + 4) * TICKS);
    chk(s == 1, "R6 single strobe after reset", s, 1);

    // R2 R3 R4: every mode with several margins
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 3; e++) begin
        int ex;
        ex = (e == 0) ? 0 : ((e == 1) ? 4 : 17);
        mode = 2'(m); extra = EW'(ex);
        bt = byte_cycles(m);
        pulse_high(3);
        low_run(bt + ex * TICKS + 4, f, r, s);
        chk(f == bt, "R2 R3 busy fall cycle", f, bt);
        chk(r == bt + ex * TICKS, "R4 idle rise cycle", r, bt + ex * TICKS);
        chk(s == 1, "R6 one strobe", s, 1);
      end
    end

    // R1: a one-cycle glitch restarts the low measurement
    mode = 2'd3; extra = 8'd2; bt = byte_cycles(3);
    pulse_high(2);
    line = 1'b0;
    repeat (bt / 2) @(negedge clk);
    pulse_high(1);
    low_run(bt + 2 * TICKS + 2, f, r, s);
    chk(f == bt, "R1 glitch restarts count", f, bt);

    // R8: very long low period
    extra = 8'd0;
    pulse_high(2);
    low_run(bt + 3000, f, r, s);
    chk(s == 1, "R8 no extra strobe", s, 1);
    chk(idle == 1'b1, "R8 idle held", idle, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule